// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides one 32-bit integer by another and returns the quotient, one quotient bit per clock. A single pulse on `start` while the block is idle latches the two operands and a 6-bit operation code. The code chooses between two's-complement and unsigned interpretation of the operands. The block then runs a fixed restoring shift-and-subtract sequence and raises `done` for one cycle with the finished quotient.

For signed work the block divides the operand magnitudes. It records the quotient sign as the exclusive-or of the two operand sign bits and negates the result after the loop if that sign is set. Quotient bits enter at the low end of the same register that holds the shifting dividend, so the dividend and the quotient share one register. A partial remainder register, cleared at every start, sits above it. Divide-by-zero and overflow are not trapped: the arithmetic runs as it is and the result follows from it. Width, code width and the two operation codes are parameters.

Top module: `int_divider`

## Requirements
- R1: After reset `busy`, `done` and `quotient` are all zero.
- R2: A `start` sampled high while `busy` is low captures `dividend`, `divisor` and `sel`. `busy` is high from the next cycle. `done` is high for exactly one cycle, beginning 33 clock edges after the accepting edge (W+1 for width W). `busy` falls on the same edge on which `done` falls.
- R3: A `start` pulse while `busy` is high is ignored. The running operation's quotient and its completion time are unchanged, and no extra completion occurs.
- R4: With `sel` = 0x24 the operands are unsigned and `quotient` is the floor of dividend/divisor.
- R5: With `sel` = 0x25 the operands are two's-complement. The quotient is rounded toward zero, and its sign is the XOR of the two operand sign bits.
- R6: Any `sel` value other than 0x25 (for example 0x00 or 0x27) performs the unsigned division of R4.
- R7: Division by zero gives all ones in unsigned mode. In signed mode it gives all ones for a non-negative dividend and 1 for a negative dividend.
- R8: In signed mode the most negative value divided by -1 yields the most negative value (0x80000000). The same operands in unsigned mode yield 0.
- R9: `quotient` holds its value from one completion until the next. It changes only on the edge on which `done` rises.
- R10: The width is a parameter. An 8-bit instance gives 43/7 = 6, and in signed mode -43/7 = -6 (0xFA).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; honoured only while idle |
| sel | input | SEL_W (6) | Operation code: 0x25 signed, anything else unsigned |
| dividend | input | W (32) | Dividend, captured on the accepting edge |
| divisor | input | W (32) | Divisor, captured on the accepting edge |
| busy | output | 1 | High from the cycle after acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W (32) | Registered quotient of the last completed operation |

## Verification
An error in the partial remainder or in the shared dividend/quotient register corrupts every quotient bit formed after it. It therefore shows as a wrong `quotient` at the next `done`, 33 cycles after start at most. A miscounted loop shows as `done` arriving early or late, or as a quotient shifted by one bit. A wrong sign flag or a missing fix-up appears only on signed operands with differing signs. For that reason the bench mixes operand signs and checks the completion cycle as well as the value.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_t;

endpackage

// File: rtl/div_sign_prep.sv
module div_sign_prep #(
  parameter int W = 32,
  parameter int SEL_W = 6,
  parameter logic [SEL_W-1:0] SEL_SIGNED = 6'h25
) (
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [SEL_W-1:0] op_sel,
  output logic [W-1:0]     mag_a,
  output logic [W-1:0]     mag_b,
  output logic             q_neg
);

  logic is_signed;
  logic a_neg;
  logic b_neg;

  always_comb begin
    is_signed = (op_sel == SEL_SIGNED);
    a_neg     = is_signed & op_a[W-1];
    b_neg     = is_signed & op_b[W-1];
    mag_a     = a_neg ? (~op_a + W'(1)) : op_a;
    mag_b     = b_neg ? (~op_b + W'(1)) : op_b;
    q_neg     = a_neg ^ b_neg;
  end

endmodule

// File: rtl/div_step_core.sv
module div_step_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] mag_a,
  input  logic [W-1:0] mag_b,
  output logic [W-1:0] quo_raw,
  output logic         last
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  dq_q;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic          running;

  // trial remainder after the one-bit shift; W+1 bits so no overflow
  logic [W:0] rem_w;
  logic [W:0] diff_w;
  logic       fits;

  always_comb begin
    rem_w  = {rem_q, dq_q[W-1]};
    diff_w = rem_w - {1'b0, dvs_q};
    fits   = (rem_w >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      dq_q    <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      running <= 1'b0;
      last    <= 1'b0;
    end else begin
      last <= 1'b0;
      if (load) begin
        rem_q   <= '0;
        dq_q    <= mag_a;
        dvs_q   <= mag_b;
        cnt_q   <= CW'(W);
        running <= 1'b1;
      end else if (running) begin
        if (fits) begin
          rem_q <= diff_w[W-1:0];
          dq_q  <= {dq_q[W-2:0], 1'b1};
        end else begin
          rem_q <= rem_w[W-1:0];
          dq_q  <= {dq_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          running <= 1'b0;
          last    <= 1'b1;
        end
      end
    end
  end

  assign quo_raw = dq_q;

  // R4: restoring step keeps the partial remainder below a nonzero divisor
  assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (rst)
    (running && dvs_q != '0) |-> (rem_q < dvs_q));

  // R2: loop counter stays within 1..W while the loop runs
  assert_count_range_R2: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt_q != '0 && cnt_q <= CW'(W)));

endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic         neg,
  input  logic [W-1:0] raw,
  output logic [W-1:0] quotient,
  output logic         done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      quotient <= '0;
      done     <= 1'b0;
    end else begin
      done <= fire;
      if (fire) quotient <= neg ? (~raw + W'(1)) : raw;
    end
  end

  // R9: the quotient only moves when a completion is reported
  assert_quotient_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(quotient) |-> done);

  // R2: completion is a single-cycle pulse
  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/int_divider.sv
module int_divider #(
  parameter int W = 32,
  parameter int SEL_W = 6,
  parameter logic [SEL_W-1:0] SEL_SIGNED = 6'h25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     dividend,
  input  logic [W-1:0]     divisor,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     quotient
);

  import div_pkg::*;

  div_state_t state_q;
  logic       load;
  logic       neg_q;
  logic       last;
  logic [W-1:0] mag_a;
  logic [W-1:0] mag_b;
  logic [W-1:0] quo_raw;
  logic       q_neg;

  assign busy = (state_q != ST_IDLE);
  assign load = start && (state_q == ST_IDLE);

  div_sign_prep #(.W(W), .SEL_W(SEL_W), .SEL_SIGNED(SEL_SIGNED)) u_prep (
    .op_a   (dividend),
    .op_b   (divisor),
    .op_sel (sel),
    .mag_a  (mag_a),
    .mag_b  (mag_b),
    .q_neg  (q_neg)
  );

  div_step_core #(.W(W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .mag_a   (mag_a),
    .mag_b   (mag_b),
    .quo_raw (quo_raw),
    .last    (last)
  );

  div_sign_fix #(.W(W)) u_fix (
    .clk      (clk),
    .rst      (rst),
    .fire     (last),
    .neg      (neg_q),
    .raw      (quo_raw),
    .quotient (quotient),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      neg_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          neg_q   <= q_neg;
        end
        ST_RUN:  if (last) state_q <= ST_FIX;
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: done is only raised while the block reports busy
  assert_done_within_busy_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  // R2: busy drops on the edge where done drops
  assert_busy_ends_with_done_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> !busy);

  // R3: a start during busy does not restart the loop
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> busy);

endmodule

// File: tb/test_int_divider.sv
module test_int_divider;

  localparam int CLK_P = 10;
  localparam int W = 32;
  localparam logic [5:0] S_SGN = 6'h25;
  localparam logic [5:0] S_UNS = 6'h24;

  logic clk = 0;
  logic rst = 1;
  logic start = 0;
  logic [5:0] sel = 0;
  logic [W-1:0] dividend = 0, divisor = 0;
  logic busy, done;
  logic [W-1:0] quotient;

  logic start8 = 0;
  logic [5:0] sel8 = 0;
  logic [7:0] a8 = 0, b8 = 0;
  logic busy8, done8;
  logic [7:0] q8;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  logic [W-1:0] last_q = 0;

  typedef struct {
    logic [W-1:0] exp;
    int           t0;
    string        req;
  } item_t;
  item_t sb[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  int_divider #(.W(W)) i_int_divider (
    .clk(clk), .rst(rst), .start(start), .sel(sel),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient)
  );

  int_divider #(.W(8)) i_int_divider_w8 (
    .clk(clk), .rst(rst), .start(start8), .sel(sel8),
    .dividend(a8), .divisor(b8),
    .busy(busy8), .done(done8), .quotient(q8)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_q(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [5:0] s);
    logic [W-1:0] r;
    if (b == '0) begin
      if (s == S_SGN && a[W-1]) r = 1;
      else r = '1;
    end else if (s == S_SGN) begin
      if (a == {1'b1, {(W-1){1'b0}}} && b == '1) r = a;
      else r = $signed(a) / $signed(b);
    end else begin
      r = a / b;
    end
    return r;
  endfunction

  // monitor: pop the expected item on every completion
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3 unexpected completion", quotient, '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(quotient == it.exp, it.req, quotient, it.exp);
        check((cyc - it.t0) == 33, "R2 latency", W'(cyc - it.t0), W'(33));
        last_q = it.exp;
      end
    end
  end

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [5:0] s, input string req, input int poke);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1; dividend = a; divisor = b; sel = s;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    it.exp = ref_q(a, b, s);
    it.t0 = cyc;
    it.req = req;
    sb.push_back(it);
    check(busy == 1'b1, "R2 busy after accept", W'(busy), W'(1));
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      start = 1; dividend = ~a; divisor = 3; sel = S_UNS;
      @(negedge clk);
      start = 0;
    end
  endtask

  task automatic drain;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run8(input logic [7:0] a, input logic [7:0] b, input logic [5:0] s,
                      input logic [7:0] exp);
    int n;
    @(negedge clk);
    start8 = 1; a8 = a; b8 = b; sel8 = s;
    @(negedge clk);
    start8 = 0;
    n = 0;
    while (!done8 && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(done8 && q8 == exp, "R10 8-bit quotient", W'(q8), W'(exp));
  endtask

  initial begin
    #(CLK_P*100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && quotient == 0, "R1 reset state",
          {quotient[W-3:0], busy, done}, '0);
    rst = 0;
    @(negedge clk);
    check(busy == 0 && done == 0 && quotient == 0, "R1 idle after reset",
          {quotient[W-3:0], busy, done}, '0);

    // R4 unsigned
    issue(43, 7, S_UNS, "R4 43/7", 0);
    issue(100, 10, S_UNS, "R4 100/10", 0);
    issue('1, 1, S_UNS, "R4 max/1", 0);
    issue(5, '1, S_UNS, "R4 5/max", 0);
    issue(32'hDEADBEEF, 32'h1234, S_UNS, "R4 large", 0);
    // R5 signed
    issue(-32'sd43, 7, S_SGN, "R5 -43/7", 0);
    issue(43, -32'sd7, S_SGN, "R5 43/-7", 0);
    issue(-32'sd43, -32'sd7, S_SGN, "R5 -43/-7", 0);
    issue(1, -32'sd2, S_SGN, "R5 1/-2 truncates", 0);
    // R6 other codes
    issue('1, 2, 6'h00, "R6 sel 0x00 unsigned", 0);
    issue(-32'sd8, 2, 6'h27, "R6 sel 0x27 unsigned", 0);
    // R7 divide by zero
    issue(123, 0, S_UNS, "R7 unsigned /0", 0);
    issue(5, 0, S_SGN, "R7 signed positive /0", 0);
    issue(-32'sd5, 0, S_SGN, "R7 signed negative /0", 0);
    // R8 most negative
    issue(32'h80000000, '1, S_SGN, "R8 min/-1 signed", 0);
    issue(32'h80000000, 1, S_SGN, "R8 min/1 signed", 0);
    issue(32'h80000000, '1, S_UNS, "R8 min/max unsigned", 0);
    // R3 start while busy
    issue(1000, 7, S_UNS, "R3 ignored start", 5);
    issue(-32'sd999, 3, S_SGN, "R3 ignored start late", 30);
    drain();
    check(sb.size() == 0, "R3 no pending items", W'(sb.size()), '0);
    // R9 hold
    repeat (6) @(negedge clk);
    check(quotient == last_q && !done, "R9 quotient holds", quotient, last_q);
    check(busy == 0, "R2 busy low after done", W'(busy), '0);

    for (int i = 0; i < 50; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = (i % 3 == 0) ? W'($urandom_range(1, 300)) : $urandom;
      if (i % 2 == 0) issue(ra, rb, S_SGN, "R5 random signed", 0);
      else issue(ra, rb, S_UNS, "R4 random unsigned", 0);
    end
    drain();
    check(sb.size() == 0, "R2 all completions seen", W'(sb.size()), '0);

    run8(8'd43, 8'd7, S_UNS, 8'd6);
    run8(8'hD5, 8'd7, S_SGN, 8'hFA);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule